// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a small group of asynchronous external interrupt pins. Each pin passes through a two-flop synchronizer. The block then compares the newest synchronized sample with the one before it to find rising and falling transitions. A per-pin polarity bit selects which transition counts. When the selected transition occurs, the pin's sticky flag is set, and it stays set until software clears it.

Each flag is gated by a per-pin enable and routed to one of two registered request lines, high priority or low priority. Pins 1 and up each have a priority bit. Pin 0 has no usable priority bit and always goes to the high line. A separate wake-up output is formed combinationally from the enabled flags, so it works while the core sleeps. When a wake-up happens during sleep and the global interrupt enable is on, the block emits a one-cycle vector-branch pulse.

Software configures the block through a simple write port. Each write carries an address and a data word with one bit per pin. The port has no back-pressure: every cycle with `reg_we` high takes effect on that clock edge.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A change on a pin input sets the pin's flag on the third rising clock edge after the change. The flag is visible on `flags` just after that edge.
- R2: Write address 0 holds the polarity bits. A bit of 1 makes that pin respond to a rising transition and a bit of 0 to a falling one. The opposite transition never sets the flag.
- R3: A flag stays set until software writes a 1 to that bit position at address 3. Data bits of 0 at address 3 leave the flags unchanged.
- R4: If a detected transition and a clear of the same flag fall in the same cycle, the flag ends up set.
- R5: `irq_hi` and `irq_lo` are registered. Each reflects the enabled, flagged sources one edge after the flags change. Address 2 holds the priority bits, where 1 means high and 0 means low. Bit 0 is ignored, and pin 0 always requests at high priority.
- R6: Address 1 holds the enable bits. A disabled pin still gets its flag set but drives neither request line nor `wake_req`.
- R7: `wake_req` is high in the same cycle in which any enabled pin has its flag set, whatever that pin's priority.
- R8: `vector_req` pulses for exactly one cycle, one edge after `wake_req` first rises while `sleeping` is high. The pulse happens only if `global_en` is high. With `global_en` low there is no pulse.
- R9: After reset all polarity, enable and priority bits are 0 (apart from pin 0's fixed high priority), all flags are clear, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | N_PINS | Asynchronous external interrupt pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 polarity, 1 enable, 2 priority, 3 flag clear |
| reg_wdata | input | N_PINS | Write data, one bit per pin |
| sleeping | input | 1 | Core is in sleep |
| global_en | input | 1 | Global interrupt enable |
| flags | output | N_PINS | Sticky per-pin flags |
| irq_hi | output | 1 | High-priority interrupt request |
| irq_lo | output | 1 | Low-priority interrupt request |
| wake_req | output | 1 | Combinational wake-up request |
| vector_req | output | 1 | One-cycle vector-branch pulse after wake-up |

## Verification
The bench drives a pin in the direction its polarity bit does not select and expects no flag; a design with inverted polarity would flag it. It lines a software clear up with the cycle in which a transition is detected; a design that lets the clear win would lose that event. It writes 0 into pin 0's priority bit and expects a high request anyway, and it writes a clear word of zeros and expects the flags to stay as they were. The wake-up cases are run with global enable both on and off: a missing gate would send a vector pulse in the second case, and a pulse that is not one cycle long would show up in the cycle after it.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_POLARITY = 2'd0,
    REG_ENABLE   = 2'd1,
    REG_PRIORITY = 2'd2,
    REG_CLEAR    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int N_PINS = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] rise_evt,
  output logic [N_PINS-1:0] fall_evt
);
  localparam int LAST = STAGES - 1;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], pin_in[p]};
        prev  <= chain[LAST];
      end
    end
    assign rise_evt[p] = chain[LAST] & ~prev;
    assign fall_evt[p] = ~chain[LAST] & prev;
  end
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int N_PINS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N_PINS-1:0] reg_wdata,
  output logic [N_PINS-1:0] cfg_rise,
  output logic [N_PINS-1:0] cfg_en,
  output logic [N_PINS-1:0] cfg_prio,
  output logic [N_PINS-1:0] clr_mask
);
  logic [N_PINS-1:0] rise_q, en_q, prio_q;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(reg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      en_q   <= '0;
      prio_q <= '0;
    end else if (reg_we) begin
      case (sel)
        REG_POLARITY: rise_q <= reg_wdata;
        REG_ENABLE:   en_q   <= reg_wdata;
        REG_PRIORITY: prio_q <= reg_wdata;
        default:      ;
      endcase
    end
  end

  assign clr_mask = (reg_we && sel == REG_CLEAR) ? reg_wdata : '0;
  assign cfg_rise = rise_q;
  assign cfg_en   = en_q;
  // pin 0 is hardwired to the high request line
  assign cfg_prio = {prio_q[N_PINS-1:1], 1'b1};
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags #(
  parameter int N_PINS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] rise_evt,
  input  logic [N_PINS-1:0] fall_evt,
  input  logic [N_PINS-1:0] cfg_rise,
  input  logic [N_PINS-1:0] clr_mask,
  output logic [N_PINS-1:0] flag_q
);
  logic [N_PINS-1:0] hit;

  assign hit = (rise_evt & cfg_rise) | (fall_evt & ~cfg_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_mask) | hit;  // set wins
  end
endmodule

// File: rtl/ext_irq_req.sv
module ext_irq_req #(
  parameter int N_PINS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] flag_q,
  input  logic [N_PINS-1:0] cfg_en,
  input  logic [N_PINS-1:0] cfg_prio,
  input  logic              sleeping,
  input  logic              global_en,
  output logic              irq_hi,
  output logic              irq_lo,
  output logic              wake_req,
  output logic              vector_req
);
  logic [N_PINS-1:0] live;
  logic              hi_q, lo_q, wake_d, vec_q, wake_now;

  assign live     = flag_q & cfg_en;
  assign wake_req = |live;
  assign wake_now = sleeping & wake_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      wake_d <= 1'b0;
      vec_q  <= 1'b0;
    end else begin
      hi_q   <= |(live & cfg_prio);
      lo_q   <= |(live & ~cfg_prio);
      wake_d <= wake_now;
      vec_q  <= wake_now & ~wake_d & global_en;
    end
  end

  assign irq_hi     = hi_q;
  assign irq_lo     = lo_q;
  assign vector_req = vec_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int N_PINS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [N_PINS-1:0] reg_wdata,
  input  logic              sleeping,
  input  logic              global_en,
  output logic [N_PINS-1:0] flags,
  output logic              irq_hi,
  output logic              irq_lo,
  output logic              wake_req,
  output logic              vector_req
);
  logic [N_PINS-1:0] rise_evt, fall_evt;
  logic [N_PINS-1:0] cfg_rise, cfg_en, cfg_prio, clr_mask, flag_q;

  ext_irq_sync #(.N_PINS(N_PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  ext_irq_regs #(.N_PINS(N_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cfg_rise(cfg_rise), .cfg_en(cfg_en),
    .cfg_prio(cfg_prio), .clr_mask(clr_mask)
  );

  ext_irq_flags #(.N_PINS(N_PINS)) u_flags (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .cfg_rise(cfg_rise), .clr_mask(clr_mask), .flag_q(flag_q)
  );

  ext_irq_req #(.N_PINS(N_PINS)) u_req (
    .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .cfg_en(cfg_en),
    .cfg_prio(cfg_prio), .sleeping(sleeping), .global_en(global_en),
    .irq_hi(irq_hi), .irq_lo(irq_lo), .wake_req(wake_req),
    .vector_req(vector_req)
  );

  assign flags = flag_q;
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
  parameter int N_PINS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [N_PINS-1:0] flags,
  input logic [N_PINS-1:0] cfg_en,
  input logic [N_PINS-1:0] cfg_prio,
  input logic              global_en,
  input logic              irq_hi,
  input logic              irq_lo,
  input logic              wake_req,
  input logic              vector_req
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 2'd3) |=> ((flags & $past(flags)) == $past(flags))); // R3
  AST_PIN0_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && cfg_en[0]) |=> irq_hi); // R5
  AST_LOW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> $past(|(flags & cfg_en & ~cfg_prio))); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en == '0) |=> (!irq_hi && !irq_lo)); // R6
  AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (|flags)); // R7
  AST_VEC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    vector_req |-> $past(global_en)); // R8
  AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    vector_req |=> !vector_req); // R8
endmodule

bind ext_irq_ctrl ext_irq_chk #(.N_PINS(N_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .flags(flags), .cfg_en(cfg_en), .cfg_prio(cfg_prio),
  .global_en(global_en), .irq_hi(irq_hi), .irq_lo(irq_lo),
  .wake_req(wake_req), .vector_req(vector_req)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic         reg_we = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic         sleeping = 1'b0;
  logic         global_en = 1'b0;
  logic [N-1:0] flags;
  logic         irq_hi, irq_lo, wake_req, vector_req;

  always #10 clk = ~clk;  // 50 MHz

  ext_irq_ctrl #(.N_PINS(N)) i_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .sleeping(sleeping),
    .global_en(global_en), .flags(flags), .irq_hi(irq_hi),
    .irq_lo(irq_lo), .wake_req(wake_req), .vector_req(vector_req)
  );

  typedef struct {
    string        tag;
    logic [N-1:0] fl;
    logic         hi, lo, wk, vec;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic [N-1:0] fl,
                            input logic hi, input logic lo,
                            input logic wk, input logic vec);
    exp_t e;
    e.tag = tag; e.fl = fl; e.hi = hi; e.lo = lo; e.wk = wk; e.vec = vec;
    sb.push_back(e);
  endtask

  // monitor: pops expectations and compares at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_checks++;
      if (flags !== e.fl || irq_hi !== e.hi || irq_lo !== e.lo ||
          wake_req !== e.wk || vector_req !== e.vec) begin
        n_fail++;
        $display("FAIL %s: got flags=%b hi=%b lo=%b wake=%b vec=%b, expected flags=%b hi=%b lo=%b wake=%b vec=%b",
                 e.tag, flags, irq_hi, irq_lo, wake_req, vector_req,
                 e.fl, e.hi, e.lo, e.wk, e.vec);
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    expect_out("R9 reset", 4'b0000, 0, 0, 0, 0);

    wr(2'd0, 4'b0101);  // pins 0,2 rising; 1,3 falling
    wr(2'd1, 4'b1111);
    wr(2'd2, 4'b1010);  // bit 0 written 0, pin 2 low

    pin_in[1] = 1'b1; tick(4);
    expect_out("R2 unselected rising edge", 4'b0000, 0, 0, 0, 0);
    pin_in[1] = 1'b0; tick(3);
    expect_out("R1 R7 falling edge flag", 4'b0010, 0, 0, 1, 0);
    tick(1);
    expect_out("R5 high request", 4'b0010, 1, 0, 1, 0);

    wr(2'd3, 4'b0000);
    expect_out("R3 zero clear keeps flag", 4'b0010, 1, 0, 1, 0);
    wr(2'd3, 4'b0010);
    expect_out("R3 clear flag", 4'b0000, 1, 0, 0, 0);
    tick(1);
    expect_out("R5 request drops", 4'b0000, 0, 0, 0, 0);

    pin_in[2] = 1'b1; tick(3);
    expect_out("R7 low prio wake", 4'b0100, 0, 0, 1, 0);
    tick(1);
    expect_out("R5 low request", 4'b0100, 0, 1, 1, 0);
    wr(2'd3, 4'b0100); tick(1);
    expect_out("R3 cleared", 4'b0000, 0, 0, 0, 0);

    pin_in[0] = 1'b1; tick(4);
    expect_out("R5 pin0 forced high", 4'b0001, 1, 0, 1, 0);
    wr(2'd3, 4'b0001); tick(1);

    wr(2'd1, 4'b0000);
    pin_in[0] = 1'b0; tick(4);
    pin_in[0] = 1'b1; tick(3);
    expect_out("R6 disabled flag sets, no wake", 4'b0001, 0, 0, 0, 0);
    tick(1);
    expect_out("R6 disabled no request", 4'b0001, 0, 0, 0, 0);
    wr(2'd3, 4'b0001);
    wr(2'd1, 4'b1111);
    expect_out("R6 re-enabled idle", 4'b0000, 0, 0, 0, 0);

    pin_in[3] = 1'b1; tick(4);
    expect_out("R2 pin3 rising ignored", 4'b0000, 0, 0, 0, 0);
    pin_in[3] = 1'b0; tick(2);
    wr(2'd3, 4'b1000);  // clear lands with the detected edge
    expect_out("R4 set beats clear", 4'b1000, 0, 0, 1, 0);
    tick(1);
    expect_out("R5 pin3 high request", 4'b1000, 1, 0, 1, 0);
    wr(2'd3, 4'b1000); tick(1);

    pin_in[0] = 1'b0; tick(4);
    sleeping = 1'b1; global_en = 1'b1;
    pin_in[0] = 1'b1; tick(3);
    expect_out("R7 wake in sleep", 4'b0001, 0, 0, 1, 0);
    tick(1);
    expect_out("R8 vector pulse", 4'b0001, 1, 0, 1, 1);
    tick(1);
    expect_out("R8 pulse one cycle", 4'b0001, 1, 0, 1, 0);
    wr(2'd3, 4'b0001); tick(1);
    expect_out("R3 clear in sleep", 4'b0000, 0, 0, 0, 0);

    global_en = 1'b0;
    pin_in[0] = 1'b0; tick(4);
    pin_in[0] = 1'b1; tick(3);
    expect_out("R8 wake without global enable", 4'b0001, 0, 0, 1, 0);
    tick(1);
    expect_out("R8 no vector pulse", 4'b0001, 1, 0, 1, 0);
    tick(1);
    expect_out("R8 still no pulse", 4'b0001, 1, 0, 1, 0);

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule